// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside a 4-bit core's instruction sequencer and decides when a pending interrupt is taken. Up to fifteen request lines are watched. A request is taken only while the core's interrupt enable flag is set, and only at the end of an instruction. The one exception is a core that is asleep: it is woken straight away. Once a request is taken, the block owns the core for two inserted dummy instruction slots. In the first cycle it asks for the 13-bit return address to be pushed and for the enable flag to be cleared. It then issues a one-cycle forced jump to the vector of the winning line, at page 1 of the bank that was current when the request was taken.

A page-set instruction and the branch that follows it form one unit, and no request is taken between the two. The core signals this by raising `pset_armed` together with the end-of-instruction strobe of the page-set. Acceptance then moves to the next instruction boundary, which is the end of the branch. With the default slot length of six clocks, the forced jump comes 13 cycles after the accepting boundary. Adding the up to 12 clocks of the instruction that was running gives the 13 to 25 clock entry latency. From sleep, one wake cycle comes before the dummy slots, so the jump comes 14 cycles after acceptance.

Top module: `int_entry_seq`

## Requirements
- R1: After reset `busy`, `slot_no`, `push_stb`, `ien_clr`, `wake_stb` and `jump_stb` are all 0.
- R2: No request is taken while `irq_en` is 0 or while no `irq_req` line is 1. The block stays idle (`busy` 0).
- R3: When several lines are active, line k with the lowest index wins. The jump target is bank in bit 12, page 1 in bits 11:8, 0 in bits 7:4 and step k+1 in bits 3:0.
- R4: An awake core is taken only in a cycle with `instr_end` 1. Requests in other cycles wait and do not start entry.
- R5: The cycle after acceptance carries a one-cycle `push_stb` with `push_pc` equal to the `ret_pc` sampled at acceptance, and `ien_clr` in that same cycle.
- R6: After acceptance, `slot_no` is 1 for SLOT_CLKS cycles and then 2 for SLOT_CLKS cycles. `jump_stb` follows for exactly one cycle, 13 cycles after the accepting boundary at defaults, and then `busy` falls.
- R7: The bank in the jump target is `cur_bank` as sampled at acceptance. Later changes of `cur_bank` have no effect on it.
- R8: A boundary with `pset_armed` 1 is not accepted. The next boundary with `pset_armed` 0 is accepted.
- R9: With `sleep_mode` 1, an enabled request is taken without `instr_end`. `wake_stb` pulses with `push_stb`, and WAKE_CLKS wake cycles (`slot_no` 0, `busy` 1) come before the slots, so the jump comes 14 cycles after acceptance at defaults.
- R10: While `busy` is 1, `instr_end`, `irq_en` and new requests have no effect on the slot sequence or on the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_VEC | Request lines, line k maps to vector step k+1 |
| irq_en | input | 1 | Core interrupt enable flag |
| instr_end | input | 1 | Last cycle of the current instruction |
| pset_armed | input | 1 | The ending instruction is a page-set |
| sleep_mode | input | 1 | Core is asleep |
| cur_bank | input | 1 | Current program bank |
| ret_pc | input | 13 | Address to resume at after service |
| busy | output | 1 | Entry sequence in progress |
| slot_no | output | 2 | 0 none or wake, 1 first dummy slot, 2 second dummy slot |
| push_stb | output | 1 | Push `push_pc` onto the stack |
| push_pc | output | 13 | Captured return address |
| ien_clr | output | 1 | Clear the interrupt enable flag |
| wake_stb | output | 1 | Leave sleep |
| jump_stb | output | 1 | Force program counter load |
| jump_pc | output | 13 | Vector address to load |

## Verification
Entry is tried with one line alone at each end of the range, with scattered pairs and with every line at once. This shows that the lowest index wins, and that the step field is k+1 and not k. Each pattern alternates bank and return address, and the bench changes both inputs right after acceptance, so a target taken from live inputs is told apart from a captured one. Directed runs cover a disabled flag, an empty request vector, a request without a boundary and a page-set boundary. These separate the four conditions of acceptance. Other runs raise new requests and boundaries in the middle of entry, and take entry from sleep to check the one-cycle shift of the whole timeline.

// File: rtl/intsq_pkg.sv
package intsq_pkg;

  localparam int PC_W   = 13;
  localparam int STEP_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAKE = 3'd1,
    ST_SLOT1 = 3'd2,
    ST_SLOT2 = 3'd3,
    ST_JUMP = 3'd4
  } seq_state_t;

  // Vector address: bank | page 1 | step high nibble 0 | step = line + 1
  function automatic logic [PC_W-1:0] vector_target(input logic bank,
                                                    input logic [STEP_W-1:0] line);
    logic [STEP_W-1:0] step;
    step = line + 4'd1;
    return {bank, 4'h1, 4'h0, step};
  endfunction

endpackage

// File: rtl/intsq_prio_pick.sv
module intsq_prio_pick #(
  parameter int NUM_VEC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req,
  output logic               any,
  output logic [3:0]         line
);

  always_comb begin
    line = 4'd0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req[i]) line = 4'(i);
    end
  end

  assign any = |req;

  // R3: the picked line is active and no lower line is active
  a_r3_pick_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[line] && ((req & ((NUM_VEC'(1) << line) - NUM_VEC'(1))) == '0)));

endmodule

// File: rtl/intsq_slot_timer.sv
module intsq_slot_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import intsq_pkg::*;
#(
  parameter int NUM_VEC   = 15,
  parameter int SLOT_CLKS = 6,
  parameter int WAKE_CLKS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               irq_en,
  input  logic               instr_end,
  input  logic               pset_armed,
  input  logic               sleep_mode,
  input  logic               cur_bank,
  input  logic [12:0]        ret_pc,
  output logic               busy,
  output logic [1:0]         slot_no,
  output logic               push_stb,
  output logic [12:0]        push_pc,
  output logic               ien_clr,
  output logic               wake_stb,
  output logic               jump_stb,
  output logic [12:0]        jump_pc
);

  localparam int MAX_CLKS = (SLOT_CLKS > WAKE_CLKS) ? SLOT_CLKS : WAKE_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] SLOT_LOAD = CNT_W'(SLOT_CLKS - 1);
  localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CLKS - 1);

  seq_state_t state, state_nx;

  logic       req_any;
  logic [3:0] req_line;
  logic       tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic       tmr_expired;

  // named events for assertions
  logic idle;
  logic take_boundary;
  logic take_sleep;
  logic take;

  intsq_prio_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (irq_req),
    .any  (req_any),
    .line (req_line)
  );

  intsq_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  assign idle          = (state == ST_IDLE);
  assign take_boundary = idle && irq_en && req_any && instr_end && !pset_armed && !sleep_mode;
  assign take_sleep    = idle && irq_en && req_any && sleep_mode;
  assign take          = take_boundary || take_sleep;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = SLOT_LOAD;
    unique case (state)
      ST_IDLE: begin
        if (take_sleep) begin
          state_nx = ST_WAKE;
          tmr_load = 1'b1;
          tmr_val  = WAKE_LOAD;
        end else if (take_boundary) begin
          state_nx = ST_SLOT1;
          tmr_load = 1'b1;
        end
      end
      ST_WAKE: begin
        if (tmr_expired) begin
          state_nx = ST_SLOT1;
          tmr_load = 1'b1;
        end
      end
      ST_SLOT1: begin
        if (tmr_expired) begin
          state_nx = ST_SLOT2;
          tmr_load = 1'b1;
        end
      end
      ST_SLOT2: begin
        if (tmr_expired) state_nx = ST_JUMP;
      end
      ST_JUMP:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  logic [12:0] vec_q;
  logic [12:0] pc_q;
  logic        push_q;
  logic        wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      vec_q  <= '0;
      pc_q   <= '0;
      push_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      state  <= state_nx;
      push_q <= take;
      wake_q <= take_sleep;
      if (take) begin
        vec_q <= vector_target(cur_bank, req_line);
        pc_q  <= ret_pc;
      end
    end
  end

  assign busy     = !idle;
  assign slot_no  = (state == ST_SLOT1) ? 2'd1 : (state == ST_SLOT2) ? 2'd2 : 2'd0;
  assign push_stb = push_q;
  assign ien_clr  = push_q;
  assign wake_stb = wake_q;
  assign push_pc  = pc_q;
  assign jump_stb = (state == ST_JUMP);
  assign jump_pc  = vec_q;

  // R1 / R5: push pulse lasts one cycle
  a_r5_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    push_stb |=> !push_stb);

  // R5: push pulse follows an idle cycle
  a_r5_push_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> push_stb);

  // R2: disabled flag keeps the block idle
  a_r2_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !irq_en) |=> !busy);

  // R8: page-set boundary is not accepted
  a_r8_pset_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && instr_end && pset_armed && !sleep_mode) |=> !busy);

  // R6: jump follows the second slot and lasts one cycle
  a_r6_jump_after_slot2: assert property (@(posedge clk) disable iff (!rst_n)
    jump_stb |-> ($past(slot_no) == 2'd2));
  a_r6_jump_single: assert property (@(posedge clk) disable iff (!rst_n)
    jump_stb |=> (!jump_stb && !busy));

  // R3: target lies at page 1, steps 1 to 15
  a_r3_target_page1: assert property (@(posedge clk) disable iff (!rst_n)
    jump_stb |-> (jump_pc[11:4] == 8'h10 && jump_pc[3:0] != 4'h0));

  // R9: wake only from sleep
  a_r9_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |-> ($past(sleep_mode) && push_stb));

  // R10: target stable during entry
  a_r10_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !push_stb) |-> $stable(jump_pc));

endmodule

// File: tb/test_int_entry_seq.sv
module test_int_entry_seq;

  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NV-1:0] irq_req = '0;
  logic        irq_en = 1'b0;
  logic        instr_end = 1'b0;
  logic        pset_armed = 1'b0;
  logic        sleep_mode = 1'b0;
  logic        cur_bank = 1'b0;
  logic [12:0] ret_pc = '0;
  logic        busy;
  logic [1:0]  slot_no;
  logic        push_stb;
  logic [12:0] push_pc;
  logic        ien_clr;
  logic        wake_stb;
  logic        jump_stb;
  logic [12:0] jump_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  int_entry_seq i_int_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .instr_end(instr_end), .pset_armed(pset_armed), .sleep_mode(sleep_mode),
    .cur_bank(cur_bank), .ret_pc(ret_pc), .busy(busy), .slot_no(slot_no),
    .push_stb(push_stb), .push_pc(push_pc), .ien_clr(ien_clr),
    .wake_stb(wake_stb), .jump_stb(jump_stb), .jump_pc(jump_pc)
  );

  // stimulus / expected table: request, bank, return pc, expected target
  localparam int NT = 6;
  localparam logic [14:0] T_REQ [NT] = '{15'h0001, 15'h4000, 15'h00A0, 15'h7FFF, 15'h4100, 15'h0010};
  localparam logic        T_BNK [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [12:0] T_PC  [NT] = '{13'h0A35, 13'h1F00, 13'h0001, 13'h1234, 13'h0FFF, 13'h1ABC};
  localparam logic [12:0] T_EXP [NT] = '{13'h0101, 13'h110F, 13'h0106, 13'h1101, 13'h0109, 13'h1105};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one full entry; c0 is the accepting cycle
  task automatic run_entry(input logic [14:0] req, input logic bank, input logic [12:0] pc,
                           input logic [12:0] exp, input logic slp, input logic poke);
    int off;
    off = slp ? 1 : 0;
    irq_req = req; irq_en = 1'b1; cur_bank = bank; ret_pc = pc;
    instr_end = !slp; sleep_mode = slp; pset_armed = 1'b0;
    for (int n = 1; n <= 14 + off; n++) begin
      int m;
      tick();
      m = n - off;
      if (n == 1) begin
        check("R5 push_stb", push_stb, 1);
        check("R5 push_pc", push_pc, pc);
        check("R5 ien_clr", ien_clr, 1);
        check("R9 wake_stb", wake_stb, slp);
        instr_end = 1'b0; irq_en = 1'b0; irq_req = '0; sleep_mode = 1'b0;
        cur_bank = ~bank; ret_pc = ~pc;
      end
      if (n == 2) check("R5 push_stb single", push_stb, 0);
      if (poke && m == 3) begin
        irq_en = 1'b1; instr_end = 1'b1; irq_req = 15'h0001; pset_armed = 1'b0;
      end
      if (poke && m == 12) begin
        irq_en = 1'b0; instr_end = 1'b0; irq_req = '0;
      end
      if (m < 1) begin
        check("R9 wake cycle busy", busy, 1);
        check("R9 wake cycle slot", slot_no, 0);
      end else if (m <= 6) begin
        check("R6 slot1", slot_no, 1);
      end else if (m <= 12) begin
        check("R6 slot2", slot_no, 2);
        check("R6 no early jump", jump_stb, 0);
      end else if (m == 13) begin
        check("R6 jump_stb", jump_stb, 1);
        check("R3 R7 R10 jump_pc", jump_pc, exp);
      end else begin
        check("R6 idle after jump", busy, 0);
        check("R6 jump_stb single", jump_stb, 0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    check("R1 busy", busy, 0);
    check("R1 push", push_stb, 0);
    check("R1 jump", jump_stb, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 slot", slot_no, 0);
    check("R1 ien_clr", ien_clr, 0);
    check("R1 wake", wake_stb, 0);

    // table walk: priority, target encoding, bank capture
    for (int t = 0; t < NT; t++) begin
      run_entry(T_REQ[t], T_BNK[t], T_PC[t], T_EXP[t], 1'b0, 1'b0);
    end

    // R2 disabled flag
    irq_req = 15'h0004; irq_en = 1'b0; instr_end = 1'b1;
    tick(); tick();
    check("R2 disabled stays idle", busy, 0);
    // R2 no request
    irq_req = '0; irq_en = 1'b1;
    tick(); tick();
    check("R2 empty request idle", busy, 0);
    // R4 request without boundary
    irq_req = 15'h0004; instr_end = 1'b0;
    repeat (5) tick();
    check("R4 no boundary idle", busy, 0);
    check("R4 no boundary push", push_stb, 0);
    run_entry(15'h0004, 1'b1, 13'h0222, 13'h1103, 1'b0, 1'b0);

    // R8 page-set boundary defers
    irq_req = 15'h0100; irq_en = 1'b1; instr_end = 1'b1; pset_armed = 1'b1;
    tick();
    check("R8 pset boundary not taken", busy, 0);
    instr_end = 1'b0; pset_armed = 1'b0;
    repeat (4) tick();
    check("R8 branch in progress idle", busy, 0);
    run_entry(15'h0100, 1'b0, 13'h0345, 13'h0109, 1'b0, 1'b0);

    // R10 boundaries and new requests during entry
    run_entry(15'h2000, 1'b1, 13'h1777, 13'h110E, 1'b0, 1'b1);

    // R9 entry from sleep
    run_entry(15'h0040, 1'b0, 13'h0050, 13'h0107, 1'b1, 1'b0);
    // R9 sleep without enable stays asleep
    sleep_mode = 1'b1; irq_req = 15'h0040; irq_en = 1'b0;
    tick(); tick();
    check("R9 sleep disabled no wake", wake_stb, 0);
    check("R9 sleep disabled idle", busy, 0);
    sleep_mode = 1'b0; irq_req = '0;

    // R10 re-entry after return to idle
    run_entry(15'h0002, 1'b1, 13'h0999, 13'h1102, 1'b0, 1'b0);

    tick();
    summary();
    $finish;
  end

endmodule